// File: doc/BRIEF.md
# UART Word Packet Assembler

This block sits behind a UART receiver and groups the stream of received words into packets. Each word arrives on a one-cycle strobe together with its value (up to 9 bits). The block forwards every word one cycle later and marks the first and last word of each packet with strobes. It also keeps a running count of the words in the open packet.

A packet can close in two ways. The first is a word that equals a programmed delimiter value, and that word belongs to the packet it closes. The second is reaching a programmed word count. Each end condition has its own enable. When both are set, whichever condition is met first closes the packet. With both enables clear, grouping is off: words still pass through, but no packet strobes are produced. The configuration is sampled together with each word.

Top module: `uart_pkt_assembler`

## Requirements
- R1: During and right after reset, out_valid, pkt_start and pkt_end are 0 and word_count is 0.
- R2: A word presented with in_valid appears on out_data, with out_valid high, exactly one cycle later and unchanged. In a cycle that follows no in_valid, out_valid, pkt_start and pkt_end are all 0.
- R3: When delim_en and limit_en are both 0, no pkt_start or pkt_end is produced and word_count reads 0.
- R4: With grouping on, pkt_start accompanies the output of a word that arrived while word_count was 0.
- R5: With delim_en set, a word equal to delim_value raises pkt_end on that same word's output, and word_count reads 0 afterwards.
- R6: With limit_en set, the word that brings the packet's word total to limit_value or beyond raises pkt_end. A limit_value of 0 or 1 makes every word a one-word packet.
- R7: With both enables set, the packet closes on whichever condition is met first.
- R8: A word that opens a packet and also meets an end condition raises pkt_start and pkt_end in the same cycle.
- R9: After each word, word_count equals the number of words in the still-open packet, saturating at 2^LEN_W-1.
- R10: Cycles without in_valid leave word_count unchanged while grouping is on.
- R11: The delimiter compare uses all DATA_W bits, so a word differing from delim_value only in bit 8 does not close a packet.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Received-word strobe |
| in_data | input | DATA_W | Received word |
| delim_en | input | 1 | Enable delimiter end condition |
| delim_value | input | DATA_W | Delimiter word |
| limit_en | input | 1 | Enable word-count end condition |
| limit_value | input | LEN_W | Words per packet limit |
| out_valid | output | 1 | Forwarded-word strobe |
| out_data | output | DATA_W | Forwarded word |
| pkt_start | output | 1 | First word of a packet |
| pkt_end | output | 1 | Last word of a packet |
| word_count | output | LEN_W | Words in the open packet |

## Verification
The bench builds the block with DATA_W=9 and LEN_W=4. A 4-bit count saturates after 15 words, so a long run without a delimiter reaches the saturation boundary quickly. Every limit value from 0 to 5 is swept, and the 9-bit width lets a word that differs from the delimiter only in its top bit be tested. A reference model computed in the bench predicts every strobe and count through delimiter-only, limit-only, combined and disabled runs, with idle gaps in between.

// File: rtl/uart_pkt_pkg.sv
package uart_pkt_pkg;

    // Why a packet closed on a given word.
    typedef enum logic [1:0] {
        CLOSE_NONE  = 2'd0,
        CLOSE_DELIM = 2'd1,
        CLOSE_LIMIT = 2'd2,
        CLOSE_BOTH  = 2'd3
    } close_e;

    // Packet event generated for one accepted word.
    typedef struct packed {
        logic   open;
        logic   close;
        close_e why;
    } pkt_evt_t;

    function automatic close_e close_reason(input logic delim_hit, input logic limit_hit);
        close_e r;
        case ({limit_hit, delim_hit})
            2'b01:   r = CLOSE_DELIM;
            2'b10:   r = CLOSE_LIMIT;
            2'b11:   r = CLOSE_BOTH;
            default: r = CLOSE_NONE;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/pkt_delim_match.sv
module pkt_delim_match #(
    parameter int DATA_W = 9
) (
    input  logic              enable,
    input  logic [DATA_W-1:0] word,
    input  logic [DATA_W-1:0] pattern,
    output logic              hit
);
    // Full-width compare: every bit of the word must match the pattern.
    always_comb begin
        hit = enable && (word == pattern);
    end
endmodule

// File: rtl/pkt_limit_check.sv
module pkt_limit_check #(
    parameter int LEN_W = 8
) (
    input  logic             enable,
    input  logic [LEN_W-1:0] count_now,
    input  logic [LEN_W-1:0] limit,
    output logic [LEN_W-1:0] count_next,
    output logic             hit
);
    localparam logic [LEN_W-1:0] CNT_MAX = {LEN_W{1'b1}};

    // Saturating increment of the running count.
    always_comb begin
        if (count_now == CNT_MAX) begin
            count_next = CNT_MAX;
        end else begin
            count_next = count_now + 1'b1;
        end
        hit = enable && (count_next >= limit);
    end
endmodule

// File: rtl/pkt_tracker.sv
module pkt_tracker
    import uart_pkt_pkg::*;
#(
    parameter int DATA_W = 9,
    parameter int LEN_W  = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] in_data,
    input  logic              delim_en,
    input  logic [DATA_W-1:0] delim_value,
    input  logic              limit_en,
    input  logic [LEN_W-1:0]  limit_value,
    output pkt_evt_t          evt,
    output logic [LEN_W-1:0]  count_q
);
    logic             grouping;
    logic             delim_hit;
    logic             limit_hit;
    logic [LEN_W-1:0] count_next;

    pkt_delim_match #(.DATA_W(DATA_W)) u_match (
        .enable  (delim_en),
        .word    (in_data),
        .pattern (delim_value),
        .hit     (delim_hit)
    );

    pkt_limit_check #(.LEN_W(LEN_W)) u_limit (
        .enable     (limit_en),
        .count_now  (count_q),
        .limit      (limit_value),
        .count_next (count_next),
        .hit        (limit_hit)
    );

    always_comb begin
        grouping  = delim_en || limit_en;
        evt.open  = in_valid && grouping && (count_q == '0);
        evt.close = in_valid && grouping && (delim_hit || limit_hit);
        evt.why   = (in_valid && grouping) ? close_reason(delim_hit, limit_hit) : CLOSE_NONE;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            count_q <= '0;
        end else if (!grouping) begin
            count_q <= '0;
        end else if (in_valid) begin
            count_q <= evt.close ? '0 : count_next;
        end
    end
endmodule

// File: rtl/pkt_out_stage.sv
module pkt_out_stage
    import uart_pkt_pkg::*;
#(
    parameter int DATA_W = 9
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] in_data,
    input  pkt_evt_t          evt,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_data,
    output logic              pkt_start,
    output logic              pkt_end
);
    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_data  <= '0;
            pkt_start <= 1'b0;
            pkt_end   <= 1'b0;
        end else begin
            out_valid <= in_valid;
            pkt_start <= evt.open;
            pkt_end   <= evt.close;
            if (in_valid) begin
                out_data <= in_data;
            end
        end
    end
endmodule

// File: rtl/uart_pkt_assembler.sv
module uart_pkt_assembler
    import uart_pkt_pkg::*;
#(
    parameter int DATA_W = 9,
    parameter int LEN_W  = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] in_data,
    input  logic              delim_en,
    input  logic [DATA_W-1:0] delim_value,
    input  logic              limit_en,
    input  logic [LEN_W-1:0]  limit_value,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_data,
    output logic              pkt_start,
    output logic              pkt_end,
    output logic [LEN_W-1:0]  word_count
);
    pkt_evt_t evt;

    pkt_tracker #(.DATA_W(DATA_W), .LEN_W(LEN_W)) u_track (
        .clk         (clk),
        .rst         (rst),
        .in_valid    (in_valid),
        .in_data     (in_data),
        .delim_en    (delim_en),
        .delim_value (delim_value),
        .limit_en    (limit_en),
        .limit_value (limit_value),
        .evt         (evt),
        .count_q     (word_count)
    );

    pkt_out_stage #(.DATA_W(DATA_W)) u_out (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .in_data   (in_data),
        .evt       (evt),
        .out_valid (out_valid),
        .out_data  (out_data),
        .pkt_start (pkt_start),
        .pkt_end   (pkt_end)
    );
endmodule

// File: rtl/uart_pkt_assembler_chk.sv
module uart_pkt_assembler_chk #(
    parameter int DATA_W = 9,
    parameter int LEN_W  = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              in_valid,
    input logic [DATA_W-1:0] in_data,
    input logic              delim_en,
    input logic              limit_en,
    input logic              out_valid,
    input logic [DATA_W-1:0] out_data,
    input logic              pkt_start,
    input logic              pkt_end,
    input logic [LEN_W-1:0]  word_count
);
    assert_reset_clears_R1: assert property (@(posedge clk)
        rst |=> (!out_valid && !pkt_start && !pkt_end && word_count == '0));

    assert_data_forward_R2: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> (out_valid && out_data == $past(in_data)));

    assert_quiet_when_idle_R2: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> (!out_valid && !pkt_start && !pkt_end));

    assert_no_events_disabled_R3: assert property (@(posedge clk) disable iff (rst)
        (!delim_en && !limit_en) |=> (!pkt_start && !pkt_end && word_count == '0));

    assert_end_clears_count_R5: assert property (@(posedge clk) disable iff (rst)
        pkt_end |-> word_count == '0);

    assert_open_counts_one_R9: assert property (@(posedge clk) disable iff (rst)
        (pkt_start && !pkt_end) |-> word_count == LEN_W'(1));

    assert_idle_holds_count_R10: assert property (@(posedge clk) disable iff (rst)
        (!in_valid && (delim_en || limit_en)) |=> $stable(word_count));
endmodule

bind uart_pkt_assembler uart_pkt_assembler_chk #(.DATA_W(DATA_W), .LEN_W(LEN_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .in_valid   (in_valid),
    .in_data    (in_data),
    .delim_en   (delim_en),
    .limit_en   (limit_en),
    .out_valid  (out_valid),
    .out_data   (out_data),
    .pkt_start  (pkt_start),
    .pkt_end    (pkt_end),
    .word_count (word_count)
);

// File: tb/uart_pkt_assembler_test.sv
module uart_pkt_assembler_test;
    localparam int CLK_PERIOD = 10;
    localparam int DATA_W     = 9;
    localparam int LEN_W      = 4;
    localparam int CNT_MAX    = (1 << LEN_W) - 1;
    localparam int WATCHDOG   = 100000;

    logic              clk = 1'b0;
    logic              rst;
    logic              in_valid;
    logic [DATA_W-1:0] in_data;
    logic              delim_en;
    logic [DATA_W-1:0] delim_value;
    logic              limit_en;
    logic [LEN_W-1:0]  limit_value;
    logic              out_valid;
    logic [DATA_W-1:0] out_data;
    logic              pkt_start;
    logic              pkt_end;
    logic [LEN_W-1:0]  word_count;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;
    int mcount = 0;
    bit done   = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    uart_pkt_assembler #(.DATA_W(DATA_W), .LEN_W(LEN_W)) uut (
        .clk         (clk),
        .rst         (rst),
        .in_valid    (in_valid),
        .in_data     (in_data),
        .delim_en    (delim_en),
        .delim_value (delim_value),
        .limit_en    (limit_en),
        .limit_value (limit_value),
        .out_valid   (out_valid),
        .out_data    (out_data),
        .pkt_start   (pkt_start),
        .pkt_end     (pkt_end),
        .word_count  (word_count)
    );

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles == WATCHDOG && !done) begin
            fails = fails + 1;
            $display("FAIL R2 watchdog: cycles %0d expected below %0d", cycles, WATCHDOG);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    task automatic check(input string tag, input string what, input int act, input int exp);
        checks = checks + 1;
        if (act != exp) begin
            fails = fails + 1;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    task automatic do_reset();
        rst = 1'b1;
        in_valid = 1'b0;
        in_data = '0;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        mcount = 0;
    endtask

    task automatic configure(input bit de, input int dv, input bit le, input int lv);
        delim_en    = de;
        delim_value = DATA_W'(dv);
        limit_en    = le;
        limit_value = LEN_W'(lv);
    endtask

    // One word: drive at a falling edge, sample at the next falling edge.
    task automatic send(input string tag, input int w);
        bit en, first, close;
        int nxt;
        en    = delim_en || limit_en;
        first = (mcount == 0);
        nxt   = (mcount == CNT_MAX) ? CNT_MAX : mcount + 1;
        close = (delim_en && w == int'(delim_value)) || (limit_en && nxt >= int'(limit_value));
        in_valid = 1'b1;
        in_data  = DATA_W'(w);
        @(negedge clk);
        in_valid = 1'b0;
        mcount = !en ? 0 : (close ? 0 : nxt);
        check("R2", "out_valid", int'(out_valid), 1);
        check("R2", "out_data", int'(out_data), w);
        check(tag, "pkt_start", int'(pkt_start), int'(en && first));
        check(tag, "pkt_end", int'(pkt_end), int'(en && close));
        check("R9", "word_count", int'(word_count), mcount);
    endtask

    task automatic idle();
        @(negedge clk);
        if (!(delim_en || limit_en)) mcount = 0;
        check("R2", "idle out_valid", int'(out_valid), 0);
        check("R2", "idle strobes", int'(pkt_start || pkt_end), 0);
        check("R10", "idle word_count", int'(word_count), mcount);
    endtask

    initial begin
        configure(0, 0, 0, 0);
        do_reset();
        check("R1", "out_valid", int'(out_valid), 0);
        check("R1", "strobes", int'(pkt_start || pkt_end), 0);
        check("R1", "word_count", int'(word_count), 0);

        // R3: grouping disabled
        for (int i = 0; i < 10; i++) send("R3", i * 37);
        idle();

        // R6 / R8: length limit sweep, limit 0 and 1 give one-word packets
        for (int lv = 0; lv <= 5; lv++) begin
            configure(0, 0, 1, lv);
            do_reset();
            for (int i = 0; i < 12; i++) begin
                send((lv <= 1) ? "R8" : "R6", (lv * 16 + i) & 9'h1FF);
                if (i % 4 == 3) idle();
            end
        end

        // R5 / R11: delimiter, including a top-bit-only mismatch
        configure(1, 9'h00A, 0, 0);
        do_reset();
        send("R4", 9'h041);
        send("R11", 9'h10A);
        send("R5", 9'h042);
        idle();
        send("R5", 9'h00A);
        send("R8", 9'h00A);
        for (int i = 0; i < 6; i++) send("R5", (i == 4) ? 9'h00A : 9'h100 + i);

        // R7: both conditions, whichever first
        configure(1, 9'h055, 1, 3);
        do_reset();
        for (int i = 0; i < 24; i++) begin
            send("R7", (i % 5 == 1) ? 9'h055 : 9'h0F0 + i);
            if (i % 7 == 6) idle();
        end

        // R9: saturation with no matching delimiter
        configure(1, 9'h1FF, 0, 0);
        do_reset();
        for (int i = 0; i < 20; i++) send("R9", i);
        send("R5", 9'h1FF);
        send("R4", 9'h003);

        // R3: switching grouping off clears the open packet
        configure(0, 9'h1FF, 0, 0);
        idle();
        send("R3", 9'h1FF);

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule